// File: doc/BRIEF.md
# Serial Port Status Flag Controller

This block holds the two sticky status bits that a frame-based serial port reports in every outgoing frame: a reset-seen flag and a power-down flag. It also decides whether an indirect register write that arrives from the serial host is passed on to the register file. All flag updates and write decisions happen once per frame, on the cycle in which the frame strobe is high. In that cycle the block samples the clear-status bit and the write request of the incoming control word.

A plug-and-play reset command can arrive on any cycle. It is held until the next frame boundary and then raises the reset flag. From then on, host writes are refused until a frame carries the clear-status bit. The write that arrives in that clearing frame is already accepted, so a host that sets the clear bit in every frame never loses a write. A power-down request marks the next frame with the power-down flag. The port stays up for that one flagged frame and shuts at the frame boundary after it. While the port is shut, frame strobes have no effect.

Top module: `sport_flag_ctrl`

## Requirements
- R1: While `rst` is high and after it falls, `flag_rst` = 1, `flag_pd` = 1, `port_en` = 1 and `reg_wr_en` = 0, until the first live frame strobe.
- R2: A `pnp_cmd` pulse on any cycle leaves `flag_rst` unchanged until the next live frame strobe, which sets it. At a live strobe, `flag_rst` is cleared only if `ctl_clear` = 1 and no plug-and-play set event is pending. A pending set event wins over the clear.
- R3: A write request at a strobe where `flag_rst` = 1 and `ctl_clear` = 0 is dropped. `reg_wr_en` stays 0 for it.
- R4: A write request at a strobe where `flag_rst` = 1 and `ctl_clear` = 1 is accepted. `reg_wr_en` pulses for one cycle, starting the cycle after the strobe, carrying the sampled `wr_addr` and `wr_data`.
- R5: When `ctl_clear` = 1 in every frame, every write request is accepted, including those in frames where a plug-and-play command sets the flag.
- R6: After a plug-and-play set event, `flag_rst` stays 1 for at least one whole frame. It cannot fall before the following live strobe.
- R7: A live strobe with `pd_req` = 1 sets `flag_pd` while `port_en` stays 1. `port_en` falls at the next frame strobe, so at least one frame goes out with `flag_pd` = 1.
- R8: `flag_pd` is cleared at a live strobe only if `ctl_clear` = 1, `pd_active` = 0 and `pd_req` = 0. With `pd_active` = 1 it stays set.
- R9: While `port_en` = 0, frame strobes cause no write and change neither flag. A `pnp_cmd` given then stays pending. `port_en` returns to 1 on the cycle after `pd_req` falls.
- R10: With `flag_rst` = 0, a write request is accepted whether or not `ctl_clear` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| frame_strobe | input | 1 | One-cycle pulse marking the frame boundary |
| ctl_clear | input | 1 | Clear-status bit of the incoming control word, valid with the strobe |
| pnp_cmd | input | 1 | Plug-and-play reset command pulse |
| pd_req | input | 1 | Power-down request |
| pd_active | input | 1 | Device is still in power-down |
| wr_req | input | 1 | Indirect write request, valid with the strobe |
| wr_addr | input | ADDR_W | Indirect write address |
| wr_data | input | DATA_W | Indirect write data |
| flag_rst | output | 1 | Reset-seen status bit for the outgoing frame |
| flag_pd | output | 1 | Power-down status bit for the outgoing frame |
| port_en | output | 1 | Serial port enable |
| reg_wr_en | output | 1 | Qualified register file write strobe |
| reg_wr_addr | output | ADDR_W | Qualified write address |
| reg_wr_data | output | DATA_W | Qualified write data |

## Verification
The assertions check the following on every cycle:
- the reset flag falls only in a clearing frame and never in the frame that a set event lands in;
- no write leaves the block while the reset flag is set without a clear, or while the port is shut;
- the power-down flag is high on both sides of the port shutting, and falls only when power-down is over;
- a shut port freezes the reset flag.

Only the bench scenarios can show the rest:
- the ordering across frames: a command held back to the next boundary, and a command held over a whole shutdown;
- the exact addresses and data that reach the register file;
- that a continuously set clear bit lets every write through.

// File: rtl/sport_flag_pkg.sv
package sport_flag_pkg;

    // Power-down sequencing states.
    typedef enum logic [1:0] {
        PD_RUN     = 2'd0,
        PD_FLAGGED = 2'd1,
        PD_DOWN    = 2'd2
    } pd_state_e;

    // Per-frame control seen by every unit.
    typedef struct packed {
        logic strobe;   // frame boundary this cycle
        logic clear;    // clear-status bit of the control word
        logic live;     // port currently running
    } frame_ctl_t;

    // A frame boundary that the flag logic acts upon.
    function automatic logic live_edge(input frame_ctl_t fc);
        return fc.strobe & fc.live;
    endfunction

    // Sticky flag update: a set event wins over a clear.
    function automatic logic sticky_next(input logic cur, input logic set_e,
                                         input logic clr_e);
        return set_e | (cur & ~clr_e);
    endfunction

    // Host write permission for one frame.
    function automatic logic write_allowed(input logic flag, input logic clr);
        return ~flag | clr;
    endfunction

endpackage

// File: rtl/sport_pnp_flag.sv
module sport_pnp_flag
    import sport_flag_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  frame_ctl_t fc,
    input  logic       pnp_cmd,
    output logic       flag_rst
);

    logic pending_q;
    logic set_evt;
    logic act;

    assign set_evt = pending_q | pnp_cmd;
    assign act     = live_edge(fc);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_rst  <= 1'b1;
            pending_q <= 1'b0;
        end else if (act) begin
            flag_rst  <= sticky_next(flag_rst, set_evt, fc.clear);
            pending_q <= 1'b0;
        end else if (pnp_cmd) begin
            pending_q <= 1'b1;
        end
    end

    AST_RST_FALL_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $fell(flag_rst) |-> $past(fc.strobe && fc.clear && fc.live)); // R2

    AST_PNP_SET_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (act && set_evt) |=> flag_rst); // R6

endmodule

// File: rtl/sport_pd_seq.sv
module sport_pd_seq
    import sport_flag_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  frame_ctl_t fc,
    input  logic       pd_req,
    input  logic       pd_active,
    output logic       flag_pd,
    output logic       port_live
);

    pd_state_e state_q, state_d;
    logic      set_e, clr_e;

    always_comb begin
        state_d = state_q;
        case (state_q)
            PD_RUN:     if (fc.strobe && pd_req) state_d = PD_FLAGGED;
            PD_FLAGGED: if (fc.strobe)           state_d = PD_DOWN;
            PD_DOWN:    if (!pd_req)             state_d = PD_RUN;
            default:                             state_d = PD_RUN;
        endcase
    end

    assign set_e = (state_q == PD_RUN) && fc.strobe && pd_req;
    assign clr_e = (state_q == PD_RUN) && fc.strobe && fc.clear
                   && !pd_active && !pd_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PD_RUN;
            flag_pd <= 1'b1;
        end else begin
            state_q <= state_d;
            flag_pd <= sticky_next(flag_pd, set_e, clr_e);
        end
    end

    assign port_live = (state_q != PD_DOWN);

    AST_PD_FLAGGED_AT_SHUTDOWN: assert property (@(posedge clk) disable iff (rst)
        $fell(port_live) |-> (flag_pd && $past(flag_pd))); // R7

    AST_PD_CLEAR_GUARD: assert property (@(posedge clk) disable iff (rst)
        $fell(flag_pd) |-> $past(!pd_active && !pd_req && fc.clear)); // R8

endmodule

// File: rtl/sport_wr_gate.sv
module sport_wr_gate
    import sport_flag_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  frame_ctl_t        fc,
    input  logic              flag_rst,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr_q,
    output logic [DATA_W-1:0] wr_data_q
);

    logic accept;

    assign accept = live_edge(fc) && wr_req && write_allowed(flag_rst, fc.clear);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en     <= 1'b0;
            wr_addr_q <= '0;
            wr_data_q <= '0;
        end else begin
            wr_en <= accept;
            if (accept) begin
                wr_addr_q <= wr_addr;
                wr_data_q <= wr_data;
            end
        end
    end

    AST_WR_BLOCKED_BY_FLAG: assert property (@(posedge clk) disable iff (rst)
        (fc.strobe && flag_rst && !fc.clear) |=> !wr_en); // R3

    AST_WR_NEEDS_LIVE_PORT: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $past(fc.strobe && fc.live && wr_req)); // R9

endmodule

// File: rtl/sport_flag_ctrl.sv
module sport_flag_ctrl
    import sport_flag_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_strobe,
    input  logic              ctl_clear,
    input  logic              pnp_cmd,
    input  logic              pd_req,
    input  logic              pd_active,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              flag_rst,
    output logic              flag_pd,
    output logic              port_en,
    output logic              reg_wr_en,
    output logic [ADDR_W-1:0] reg_wr_addr,
    output logic [DATA_W-1:0] reg_wr_data
);

    frame_ctl_t fc;
    logic       live;

    assign fc.strobe = frame_strobe;
    assign fc.clear  = ctl_clear;
    assign fc.live   = live;
    assign port_en   = live;

    sport_pnp_flag u_pnp (
        .clk      (clk),
        .rst      (rst),
        .fc       (fc),
        .pnp_cmd  (pnp_cmd),
        .flag_rst (flag_rst)
    );

    sport_pd_seq u_pd (
        .clk       (clk),
        .rst       (rst),
        .fc        (fc),
        .pd_req    (pd_req),
        .pd_active (pd_active),
        .flag_pd   (flag_pd),
        .port_live (live)
    );

    sport_wr_gate #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_wr (
        .clk       (clk),
        .rst       (rst),
        .fc        (fc),
        .flag_rst  (flag_rst),
        .wr_req    (wr_req),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_en     (reg_wr_en),
        .wr_addr_q (reg_wr_addr),
        .wr_data_q (reg_wr_data)
    );

    AST_DOWN_FREEZES_RST_FLAG: assert property (@(posedge clk) disable iff (rst)
        !port_en |=> $stable(flag_rst)); // R9

endmodule

// File: tb/tb_sport_flag_ctrl.sv
module tb_sport_flag_ctrl;

    localparam int AW = 6;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          frame_strobe = 1'b0, ctl_clear = 1'b0, pnp_cmd = 1'b0;
    logic          pd_req = 1'b0, pd_active = 1'b1, wr_req = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          flag_rst, flag_pd, port_en, reg_wr_en;
    logic [AW-1:0] reg_wr_addr;
    logic [DW-1:0] reg_wr_data;

    typedef struct packed {
        logic [AW-1:0] a;
        logic [DW-1:0] d;
    } wr_item_t;

    wr_item_t exp_q[$];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sport_flag_ctrl #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst(rst), .frame_strobe(frame_strobe), .ctl_clear(ctl_clear),
        .pnp_cmd(pnp_cmd), .pd_req(pd_req), .pd_active(pd_active),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
        .flag_rst(flag_rst), .flag_pd(flag_pd), .port_en(port_en),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: every write the design emits must match the head of the queue.
    always @(negedge clk) begin
        if (!rst && reg_wr_en) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R3 actual=write %0h:%0h expected=none", reg_wr_addr, reg_wr_data);
            end else begin
                wr_item_t it;
                it = exp_q.pop_front();
                if (it.a !== reg_wr_addr || it.d !== reg_wr_data) begin
                    errors++;
                    $display("FAIL R4 actual=%0h:%0h expected=%0h:%0h",
                             reg_wr_addr, reg_wr_data, it.a, it.d);
                end
            end
        end
    end

    // Driver: one frame boundary with an optional write.
    task automatic frame(input bit clr, input bit wr, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, input bit acc, input string req);
        @(negedge clk);
        frame_strobe = 1'b1;
        ctl_clear    = clr;
        wr_req       = wr;
        wr_addr      = a;
        wr_data      = d;
        if (wr && acc) exp_q.push_back({a, d});
        @(negedge clk);
        frame_strobe = 1'b0;
        ctl_clear    = 1'b0;
        wr_req       = 1'b0;
        repeat (2) @(negedge clk);
        check(req, exp_q.size(), 0);
    endtask

    task automatic pnp_pulse();
        @(negedge clk);
        pnp_cmd = 1'b1;
        @(negedge clk);
        pnp_cmd = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 state during reset
        check("R1", {flag_rst, flag_pd, port_en, reg_wr_en}, 4'b1110);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check("R1", {flag_rst, flag_pd, port_en, reg_wr_en}, 4'b1110);

        frame(1'b0, 1'b1, 6'h01, 16'h1111, 1'b0, "R3");
        check("R3", flag_rst, 1);
        frame(1'b1, 1'b1, 6'h02, 16'h2222, 1'b1, "R4");
        check("R4", flag_rst, 0);
        check("R8", flag_pd, 1);               // pd_active still 1
        frame(1'b0, 1'b1, 6'h03, 16'h3333, 1'b1, "R10");
        check("R10", flag_rst, 0);
        pd_active = 1'b0;
        frame(1'b1, 1'b0, 6'h00, 16'h0000, 1'b0, "R8");
        check("R8", flag_pd, 0);

        pnp_pulse();
        check("R2", flag_rst, 0);              // not before the boundary
        frame(1'b1, 1'b1, 6'h05, 16'h5555, 1'b1, "R2");
        check("R2", flag_rst, 1);              // set wins over clear
        frame(1'b0, 1'b1, 6'h06, 16'h6666, 1'b0, "R6");
        check("R6", flag_rst, 1);
        frame(1'b1, 1'b1, 6'h07, 16'h7777, 1'b1, "R4");
        check("R4", flag_rst, 0);

        pnp_pulse();
        frame(1'b1, 1'b1, 6'h08, 16'h8888, 1'b1, "R5");
        check("R5", flag_rst, 1);
        frame(1'b1, 1'b1, 6'h09, 16'h9999, 1'b1, "R5");
        check("R5", flag_rst, 0);
        pnp_pulse();
        frame(1'b1, 1'b1, 6'h0A, 16'hAAAA, 1'b1, "R5");
        frame(1'b1, 1'b0, 6'h00, 16'h0000, 1'b0, "R5");
        check("R5", flag_rst, 0);

        pd_active = 1'b1;
        pd_req    = 1'b1;
        frame(1'b0, 1'b0, 6'h00, 16'h0000, 1'b0, "R7");
        check("R7", {flag_pd, port_en}, 2'b11);
        frame(1'b1, 1'b1, 6'h0B, 16'hBBBB, 1'b1, "R7");
        check("R7", {flag_pd, port_en}, 2'b10);

        pnp_pulse();
        frame(1'b1, 1'b1, 6'h0C, 16'hCCCC, 1'b0, "R9");
        check("R9", {flag_rst, flag_pd, port_en}, 3'b010);
        @(negedge clk);
        pd_req = 1'b0;
        check("R9", port_en, 0);
        @(negedge clk);
        check("R9", port_en, 1);
        pd_active = 1'b0;
        frame(1'b0, 1'b0, 6'h00, 16'h0000, 1'b0, "R9");
        check("R9", {flag_rst, flag_pd}, 2'b11);  // pending command applied
        frame(1'b1, 1'b0, 6'h00, 16'h0000, 1'b0, "R8");
        check("R8", {flag_rst, flag_pd}, 2'b00);

        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", {flag_rst, flag_pd, port_en, reg_wr_en}, 4'b1110);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule